// File: doc/BRIEF.md
# Fractional Clock Prescaler

This block sits in front of a UART baud generator and thins the system clock into a one-cycle enable. The ratio is programmable as M + N/8, with a 5-bit whole part M and a 3-bit eighths part N. Both fields live in one 8-bit setting register, so the ratio runs from 1 to 31.875 in steps of 0.125. Software can rewrite the setting while the block runs to reach baud rates that a whole-number divide cannot hit from a given input clock.

Internally the block counts in eighths. Each system clock adds 8 to an accumulator. When the sum reaches the divisor in eighths, the block raises the enable and removes the divisor from the sum. The gaps between enables therefore alternate between the floor and the ceiling of the ratio, and their long-run average equals the ratio exactly. After reset the ratio is 4, which matches legacy parts. Every write clears the accumulator, so no enable is timed partly by an old setting and partly by a new one.

Top module: `frac_prescaler`

## Requirements
- R1: While reset is held and at its release, the setting reads 0x20 and `tick` is low.
- R2: A write stores `wr_data` in the setting register, and `rd_data` shows it from the cycle after the write edge.
- R3: Let the divisor in eighths be D8 = 8*M + N, where M = setting[7:3] and N = setting[2:0]. Within the first D8 clock edges after a restart, `tick` is high on exactly 8 of them.
- R4: Once the first enable after a restart has occurred, each gap between consecutive enables is floor(D8/8) or ceil(D8/8) cycles.
- R5: A setting with M = 0 behaves as ratio 1 for any N: `tick` is high on every cycle after the first edge that follows the write.
- R6: A setting of 0x08 (ratio exactly 1.0) holds `tick` high continuously from the first edge after the write.
- R7: The write edge clears the accumulator and drives `tick` low. The first enable then appears exactly ceil(D8/8) edges after the write edge.
- R8: With no write after reset, `tick` rises on the 4th edge after reset release and repeats every 4 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Setting register write strobe |
| wr_data | input | 8 | New setting: whole part in [7:3], eighths in [2:0] |
| rd_data | output | 8 | Current setting readback |
| tick | output | 1 | Baud-generator clock enable, one cycle per output period |

## Verification
The bench targets the following corner cases:

- **Fractional settings.** A design that rounded the ratio to a whole number would produce the wrong pulse count within one D8 window.
- **Ratio of exactly one.** A design that pulsed on only one edge of each pair would leave `tick` low on some cycles.
- **Zero whole part.** A design that treated M = 0 as a divide by zero would stall and produce no enables.
- **Largest setting, 0xFF.** An accumulator too narrow for the sum would wrap and lose enables.
- **Write in the middle of a run.** A design that did not restart would emit its first enable early, timed by the old accumulator value.

// File: rtl/prescale_pkg.sv
package prescale_pkg;

  // Divisor expressed in eighths; a zero whole part maps to ratio 1.
  function automatic int unsigned eighths(input int unsigned whole,
                                          input int unsigned frac,
                                          input int unsigned frac_bits);
    if (whole == 0) return (32'd1 << frac_bits);
    return (whole << frac_bits) + frac;
  endfunction

  // Shortest whole-cycle gap between enables.
  function automatic int unsigned gap_floor(input int unsigned div8,
                                            input int unsigned frac_bits);
    return div8 >> frac_bits;
  endfunction

  // Longest whole-cycle gap between enables.
  function automatic int unsigned gap_ceil(input int unsigned div8,
                                           input int unsigned frac_bits);
    return (div8 + (32'd1 << frac_bits) - 1) >> frac_bits;
  endfunction

endpackage

// File: rtl/prescale_reg.sv
module prescale_reg #(
  parameter int M_W = 5,
  parameter int N_W = 3,
  parameter logic [M_W+N_W-1:0] RST_VAL = 8'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [M_W+N_W-1:0] wr_data,
  output logic [M_W+N_W-1:0] setting,
  output logic [M_W+N_W-1:0] div8,
  output logic               restart
);
  import prescale_pkg::*;
  localparam int REG_W = M_W + N_W;

  logic [M_W-1:0] whole;
  logic [N_W-1:0] frac;

  always_ff @(posedge clk) begin
    if (!rst_n)     setting <= RST_VAL;
    else if (wr_en) setting <= wr_data;
  end

  assign whole   = setting[REG_W-1:N_W];
  assign frac    = setting[N_W-1:0];
  assign div8    = REG_W'(eighths(32'(whole), 32'(frac), N_W));
  assign restart = wr_en;
endmodule

// File: rtl/frac_accum.sv
module frac_accum #(
  parameter int M_W = 5,
  parameter int N_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [M_W+N_W-1:0] div8,
  output logic               tick
);
  localparam int ACC_W = M_W + N_W;
  localparam logic [ACC_W:0] STEP = (ACC_W+1)'(1 << N_W);

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;
  logic [ACC_W:0]   rem;
  logic             wrap;

  assign sum  = {1'b0, acc} + STEP;
  assign wrap = (sum >= {1'b0, div8});
  assign rem  = sum - {1'b0, div8};

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (wrap) begin
      acc  <= rem[ACC_W-1:0];
      tick <= 1'b1;
    end else begin
      acc  <= sum[ACC_W-1:0];
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/frac_prescaler.sv
module frac_prescaler #(
  parameter int M_W = 5,
  parameter int N_W = 3,
  parameter logic [M_W+N_W-1:0] RST_VAL = 8'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [M_W+N_W-1:0] wr_data,
  output logic [M_W+N_W-1:0] rd_data,
  output logic               tick
);
  localparam int REG_W = M_W + N_W;

  logic [REG_W-1:0] div8;
  logic             restart;

  prescale_reg #(.M_W(M_W), .N_W(N_W), .RST_VAL(RST_VAL)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .setting (rd_data),
    .div8    (div8),
    .restart (restart)
  );

  frac_accum #(.M_W(M_W), .N_W(N_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .div8    (div8),
    .tick    (tick)
  );
endmodule

// File: rtl/prescale_chk.sv
module prescale_chk #(
  parameter int M_W = 5,
  parameter int N_W = 3,
  parameter logic [M_W+N_W-1:0] RST_VAL = 8'h20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [M_W+N_W-1:0] wr_data,
  input logic [M_W+N_W-1:0] rd_data,
  input logic               tick,
  input logic [M_W+N_W-1:0] div8
);
  import prescale_pkg::*;
  localparam logic [M_W+N_W-1:0] UNITY = (M_W+N_W)'(1 << N_W);

  logic [15:0] gap;
  logic        seen;
  int unsigned lo, hi;

  always_ff @(posedge clk) begin
    if (!rst_n || wr_en) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick) begin
      gap  <= 16'd1;
      seen <= 1'b1;
    end else begin
      gap  <= gap + 16'd1;
    end
  end

  assign lo = gap_floor(32'(div8), N_W);
  assign hi = gap_ceil(32'(div8), N_W);

  assert_reset_value_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (rd_data == RST_VAL) && !tick);

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  assert_gap_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen && !wr_en) |-> (32'(gap) >= lo) && (32'(gap) <= hi));

  assert_unity_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && div8 == UNITY) |=> tick);

  assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tick);
endmodule

bind frac_prescaler prescale_chk #(.M_W(M_W), .N_W(N_W), .RST_VAL(RST_VAL)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .tick    (tick),
  .div8    (div8)
);

// File: tb/test_frac_prescaler.sv
module test_frac_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tick;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  frac_prescaler i_frac_prescaler (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench's own view of the ratio in eighths.
  function automatic int d8_of(input logic [7:0] v);
    int m = int'(v) / 8;
    return (m == 0) ? 8 : int'(v);
  endfunction

  // Called at the negedge right after a restart edge.
  task automatic measure(input logic [7:0] v, input bit fresh_reset);
    int d8 = d8_of(v);
    int lo = d8 / 8;
    int hi = (d8 + 7) / 8;
    int first = 0, prev = 0, cnt = 0, badgap = 0;
    for (int k = 1; k <= 2 * d8; k++) begin
      @(negedge clk);
      if (tick) begin
        if (first == 0) first = k;
        if (k <= d8) cnt++;
        if (prev != 0 && (k - prev < lo || k - prev > hi)) badgap++;
        prev = k;
      end
    end
    chk(cnt == 8, "R3 pulses per D8 window", cnt, 8);
    chk(badgap == 0, "R4 gap floor/ceil", badgap, 0);
    if (fresh_reset) chk(first == 4, "R8 first tick after reset", first, 4);
    else             chk(first == hi, "R7 first tick after write", first, hi);
    if (d8 == 8 && v[7:3] == 0) chk(cnt == d8, "R5 M=0 every cycle", cnt, d8);
    if (v == 8'h08)              chk(cnt == d8, "R6 unity continuous", cnt, d8);
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    chk(tick == 1'b0, "R7 tick low after write", int'(tick), 0);
    chk(rd_data == v, "R2 readback", int'(rd_data), int'(v));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(rd_data == 8'h20, "R1 reset setting", int'(rd_data), 32);
    chk(tick == 1'b0, "R1 reset tick", int'(tick), 0);
    rst_n = 1'b1;
    measure(8'h20, 1'b1);
  endtask

  task automatic t_setting(input logic [7:0] v);
    do_write(v);
    measure(v, 1'b0);
  endtask

  task automatic t_midstream();
    do_write(8'h13);
    repeat (3) @(negedge clk);
    do_write(8'h1F);
    measure(8'h1F, 1'b0);
  endtask

  initial begin
    t_reset();
    t_setting(8'h0C);
    t_setting(8'h2D);
    t_setting(8'h09);
    t_setting(8'h08);
    t_setting(8'h05);
    t_setting(8'hFF);
    t_midstream();
    t_setting(8'h20);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule